// File: doc/BRIEF.md
# Reset Manager with Sticky Cause Register

This block produces the chip-wide active-low reset and records the cause of each reset in a sticky status register. Three sources lead to a reset. The first is a power-on reset input. The second is a software request written over a small register bus. The third is an external device pulling the shared open-drain reset pad low.

A software request does not reset the chip directly. It pulls the pad low, and the block then senses the pad level back through a long debounce filter. A self-requested reset and an external reset therefore follow exactly the same timed path.

The internal reset is released only when the filtered pad level goes high again. On that release, after a warm reset, the block emits a one-cycle enable-clear pulse for the first two PLLs. Three PLL lock inputs are watched for loss of lock.

Top module: `reset_manager`

## Requirements
- R1: While `por_n` is low, the status register reads 0x001 and `chip_rst_n` is low. `pad_pull_low` is low. The control register at address 1 reads 0.
- R2: After `por_n` rises, `chip_rst_n` stays low until the pad has been seen high for `DEB_CYCLES` consecutive cycles. It rises no more than `DEB_CYCLES`+4 cycles after `por_n`.
- R3: Writing 1 to bit 0 of the control register (address 1) asserts `pad_pull_low`. The request holds until the filtered pad level is low, then clears by itself, and control bit 0 reads back as 0.
- R4: A pad low pulse shorter than `DEB_CYCLES` cycles has no effect. `chip_rst_n` stays high and status bit 8 stays clear.
- R5: `chip_rst_n` is low whenever the filtered pad level is low. After a warm reset it is held low for at least `DEB_CYCLES` cycles.
- R6: Status bit 8 is set when the filtered pad level falls, whether the pad was pulled low by software or from outside.
- R7: When the filtered pad rises at the end of a warm reset, `pll_en_clr` pulses to 2'b11 for exactly one cycle. This happens once per warm reset and never after a power-on reset.
- R8: Status bits 1, 2 and 3 are set on a falling edge of `pll_lock[0]`, `pll_lock[1]` and `pll_lock[2]`, taken after a two-flop synchroniser. The flags stay set after lock returns.
- R9: A write to the status register (address 0) clears every flag bit written as 1 and leaves the others unchanged. Power-on reset clears all flags except bit 0, which it sets.
- R10: Clear the status register, then run a software warm reset with PLL1 and PLL2 losing lock when disabled. The status register then reads 0x106.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pad_in | input | 1 | Level sensed from the reset pad |
| pad_pull_low | output | 1 | Drive-low enable for the open-drain reset pad |
| chip_rst_n | output | 1 | Internal chip reset, active low |
| pll_lock | input | 3 | Lock indicators of PLL1..PLL3 (bit 0 = PLL1) |
| pll_en_clr | output | 2 | One-cycle enable-clear pulse for PLL1 (bit 0) and PLL2 (bit 1) |
| bus_addr | input | 1 | Register select: 0 status, 1 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 9 | Write data |
| bus_rdata | output | 9 | Read data of the selected register |

## Verification
The embedded properties check the cycle-level rules on every cycle:
- the filter output changes only while the synchronised pad disagrees with it;
- a filtered fall always sets the warm-reset flag;
- the software request persists until the pad is seen low;
- the enable-clear pulse lasts a single cycle;
- the internal reset rises only from a high filtered level;
- the power-on flag stays set unless it is written to clear.

Other behaviour needs whole scenarios, which only the directed bench can show:
- the total length of each reset;
- the rejection of short pad glitches;
- the interplay with a modelled PLL that loses lock when disabled, which yields the 0x106 reading;
- that exactly one enable-clear pulse occurs per warm reset.

// File: rtl/reset_manager.sv
module reset_manager #(
  parameter int DEB_CYCLES = 524288
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pad_in,
  output logic       pad_pull_low,
  output logic       chip_rst_n,
  input  logic [2:0] pll_lock,
  output logic [1:0] pll_en_clr,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [8:0] bus_wdata,
  output logic [8:0] bus_rdata
);
  localparam int CW = $clog2(DEB_CYCLES);

  logic [1:0]    pad_sync;
  logic          filt, filt_d;
  logic [CW-1:0] cnt;
  logic          req, warm_pend;
  logic [2:0]    lk1, lk2, lk3;
  logic          f_por, f_warm;
  logic [2:0]    f_unl;

  wire pad_s     = pad_sync[1];
  wire filt_rise = filt & ~filt_d;
  wire filt_fall = ~filt & filt_d;
  wire stat_wr   = bus_wr & ~bus_addr;
  wire ctrl_wr   = bus_wr & bus_addr;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pad_sync <= 2'b00;
      filt     <= 1'b0;
      filt_d   <= 1'b0;
      cnt      <= '0;
    end else begin
      pad_sync <= {pad_sync[0], pad_in};
      filt_d   <= filt;
      if (pad_s == filt)
        cnt <= '0;
      else if (cnt == CW'(DEB_CYCLES - 1)) begin
        filt <= pad_s;
        cnt  <= '0;
      end else
        cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) chip_rst_n <= 1'b0;
    else        chip_rst_n <= filt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                 req <= 1'b0;
    else if (!filt)             req <= 1'b0;
    else if (ctrl_wr && bus_wdata[0]) req <= 1'b1;

  assign pad_pull_low = req;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      warm_pend  <= 1'b0;
      pll_en_clr <= 2'b00;
    end else begin
      if (filt_fall)      warm_pend <= 1'b1;
      else if (filt_rise) warm_pend <= 1'b0;
      pll_en_clr <= {2{filt_rise & warm_pend}};
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      lk1 <= '0; lk2 <= '0; lk3 <= '0;
    end else begin
      lk1 <= pll_lock; lk2 <= lk1; lk3 <= lk2;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      f_por  <= 1'b1;
      f_warm <= 1'b0;
      f_unl  <= 3'b000;
    end else begin
      if (stat_wr && bus_wdata[0]) f_por <= 1'b0;
      if (filt_fall)                f_warm <= 1'b1;
      else if (stat_wr && bus_wdata[8]) f_warm <= 1'b0;
      for (int i = 0; i < 3; i++)
        if (lk3[i] && !lk2[i])           f_unl[i] <= 1'b1;
        else if (stat_wr && bus_wdata[i+1]) f_unl[i] <= 1'b0;
    end

  assign bus_rdata = bus_addr ? {8'b0, req} : {f_warm, 4'b0000, f_unl, f_por};

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (pad_s == filt) |=> $stable(filt)); // R4
  AST_WARM_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    $fell(filt) |=> f_warm); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (req && filt && !(ctrl_wr && 1'b0)) |=> req); // R3
  AST_PLL_PULSE: assert property (@(posedge clk) disable iff (!por_n)
    (pll_en_clr != 2'b00) |=> (pll_en_clr == 2'b00)); // R7
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chip_rst_n) |-> $past(filt)); // R5
  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (f_por && !(stat_wr && bus_wdata[0])) |=> f_por); // R9
endmodule

// File: tb/test_reset_manager.sv
module test_reset_manager;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_low = 1'b0;
  logic       pad_pull_low, chip_rst_n;
  logic [1:0] pll_en_clr;
  logic       lock3 = 1'b1;
  logic       pll1_off = 1'b0, pll2_off = 1'b0, relock = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0;
  logic [8:0] bus_wdata = '0, bus_rdata;
  int         checks = 0, errors = 0, pulses = 0;

  wire       pad_in   = !(pad_pull_low || ext_low);
  wire [2:0] pll_lock = {lock3, !pll2_off, !pll1_off};

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (pll_en_clr == 2'b11) pulses <= pulses + 1;
    if (pll_en_clr[0]) pll1_off <= 1'b1; else if (relock) pll1_off <= 1'b0;
    if (pll_en_clr[1]) pll2_off <= 1'b1; else if (relock) pll2_off <= 1'b0;
  end

  reset_manager #(.DEB_CYCLES(DEB)) i_reset_manager (
    .clk(clk), .por_n(por_n), .pad_in(pad_in), .pad_pull_low(pad_pull_low),
    .chip_rst_n(chip_rst_n), .pll_lock(pll_lock), .pll_en_clr(pll_en_clr),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [8:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic wait_rst_high(output int n);
    n = 0;
    while (!chip_rst_n && n < 100000) begin @(negedge clk); n++; end
  endtask

  task automatic t_por;
    int v, n;
    @(negedge clk); por_n = 1'b0; cycles(3);
    rd(0, v); check("R1 status", v, 'h001);
    rd(1, v); check("R1 ctrl", v, 0);
    check("R1 chip_rst_n", int'(chip_rst_n), 0);
    check("R1 pad_pull_low", int'(pad_pull_low), 0);
    por_n = 1'b1;
    wait_rst_high(n);
    check("R2 held min", int'(n >= DEB), 1);
    check("R2 held max", int'(n <= DEB + 4), 1);
    cycles(3);
    check("R7 no pulse after POR", pulses, 0);
  endtask

  task automatic t_sw_warm;
    int v, n, p0;
    wr(0, 9'h10F);
    rd(0, v); check("R9 clear all", v, 0);
    p0 = pulses;
    wr(1, 9'h001);
    check("R3 pad pulled", int'(pad_pull_low), 1);
    n = 0;
    while (chip_rst_n && n < 1000) begin @(negedge clk); n++; end
    check("R5 reset entered", int'(chip_rst_n), 0);
    wait_rst_high(n);
    check("R5 low length", int'(n >= DEB), 1);
    check("R3 request cleared", int'(pad_pull_low), 0);
    rd(1, v); check("R3 ctrl reads 0", v, 0);
    cycles(6);
    check("R7 one pulse", pulses - p0, 1);
    rd(0, v); check("R10 status 0x106", v, 'h106);
    check("R6 warm flag", (v >> 8) & 1, 1);
    relock = 1'b1; cycles(1); relock = 1'b0; cycles(4);
    rd(0, v); check("R8 flags sticky", v & 'h6, 'h6);
  endtask

  task automatic t_glitch;
    int v, lowseen = 0;
    wr(0, 9'h10F);
    ext_low = 1'b1;
    for (int i = 0; i < DEB/2; i++) begin @(negedge clk); if (!chip_rst_n) lowseen = 1; end
    ext_low = 1'b0;
    for (int i = 0; i < DEB + 4; i++) begin @(negedge clk); if (!chip_rst_n) lowseen = 1; end
    check("R4 no reset", lowseen, 0);
    rd(0, v); check("R4 no warm flag", v, 0);
  endtask

  task automatic t_ext_warm;
    int v, n, p0;
    wr(0, 9'h10F);
    p0 = pulses;
    ext_low = 1'b1;
    cycles(DEB + 6);
    check("R5 ext reset low", int'(chip_rst_n), 0);
    check("R3 no pull without request", int'(pad_pull_low), 0);
    rd(0, v); check("R6 ext warm flag", (v >> 8) & 1, 1);
    ext_low = 1'b0;
    wait_rst_high(n);
    check("R5 ext release", int'(chip_rst_n), 1);
    cycles(6);
    check("R7 ext pulse", pulses - p0, 1);
    relock = 1'b1; cycles(1); relock = 1'b0; cycles(4);
  endtask

  task automatic t_lock;
    int v;
    wr(0, 9'h10F);
    lock3 = 1'b0; cycles(5);
    rd(0, v); check("R8 PLL3 unlock flag", v, 'h008);
    lock3 = 1'b1; cycles(5);
    rd(0, v); check("R8 PLL3 flag sticky", v, 'h008);
    wr(0, 9'h001);
    rd(0, v); check("R9 unwritten bit kept", v, 'h008);
    wr(0, 9'h008);
    rd(0, v); check("R9 written bit cleared", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_por();
    t_sw_warm();
    t_glitch();
    t_ext_warm();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule